// File: doc/BRIEF.md
# Strobe-Snooping Message Capture Buffer

This block listens to an 8-bit data bus that it does not own. It captures the bus value each time an active-low I/O chip-select strobe falls. Captured bytes go into a local 256-entry circular store. No handshake is involved: the strobe alone decides when a byte is taken, much as a peripheral-triggered DMA channel would. A local consumer pops bytes one at a time in arrival order.

The producer on the far side keeps a small FIFO descriptor in its own memory. The input index sits two bytes below a base address and the output index sits one byte below it. After an init command has stored a nonzero base, every successful pop is reported back: the block requests the remote bus, writes its new read count into the output-index byte, and releases the bus. The producer can then tell how much space is free. The init command synchronises the descriptor by copying the remote input index into the remote output index. Capture keeps running during all remote bus traffic.

Sequencer states: `ST_IDLE`, `ST_WB_ACQ`, `ST_WB_WRITE`, `ST_IN_ACQ`, `ST_IN_READ`, `ST_IN_LATCH`, `ST_IN_WRITE`, `ST_RELEASE`.

Transitions:
- `ST_IDLE` to `ST_IN_ACQ` on an accepted init.
- `ST_IDLE` to `ST_WB_ACQ` on an accepted pop while the base is nonzero.
- `ST_WB_ACQ` to `ST_WB_WRITE` when acknowledge is high.
- `ST_WB_WRITE` to `ST_RELEASE` once the write is issued.
- `ST_IN_ACQ` to `ST_IN_READ` when acknowledge is high.
- `ST_IN_READ` to `ST_IN_LATCH` once the read is issued.
- `ST_IN_LATCH` to `ST_IN_WRITE` unconditionally.
- `ST_IN_WRITE` to `ST_RELEASE` once the write is issued; the base is stored on this transition.
- `ST_RELEASE` to `ST_IDLE` when acknowledge is low.

Top module: `msgcap_snoop_buffer`

## Requirements
- R1: After reset `pop_valid`, `overflow`, `busy`, `bus_req`, `mem_we` and `mem_re` are 0. The store is empty. The read count and the remote base are 0.
- R2: `strobe_n` passes through a two-flop synchroniser. Each detected high-to-low transition writes the `snoop_data` value into the next slot of the 256-entry circular store. The write position then advances by one.
- R3: A pop while the read count equals the write position is refused. `pop_valid` stays 0 and no state changes.
- R4: An accepted pop raises `pop_valid` for one cycle, in the cycle after `pop_req`. `pop_data` carries the oldest unread byte. The read count advances by one and wraps from 255 to 0.
- R5: A capture that arrives while 255 bytes are unread sets `overflow`, which stays set until reset. The byte is still written, and the write position still advances.
- R6: After an accepted pop with a nonzero base, the block does the following in order:
  - raises `bus_req`;
  - waits for `bus_ack`;
  - issues one `mem_we` cycle writing the new read count to address base-1;
  - drops `bus_req`;
  - returns to idle once `bus_ack` is low.
- R7: While the base is 0, pops cause no remote bus activity.
- R8: An accepted init takes the bus and reads address `init_base`-2. Read data is expected on `mem_rdata` in the cycle after `mem_re`. The block writes that byte to `init_base`-1, releases the bus, and then holds `init_base` as the base. Address arithmetic wraps at `ADDR_W` bits.
- R9: `pop_req` and `init_req` are ignored while `busy` is 1. When both arrive together in idle, the init is taken and the pop is ignored.
- R10: Captures continue while a remote bus sequence is in progress.
- R11: `mem_we` and `mem_re` are only asserted while both `bus_req` and `bus_ack` are high, and never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 1 | Asynchronous active-low capture strobe |
| snoop_data | input | DATA_W | Snooped data bus |
| pop_req | input | 1 | Local pop request |
| pop_valid | output | 1 | Pop returned a byte |
| pop_data | output | DATA_W | Popped byte |
| init_req | input | 1 | Init command |
| init_base | input | ADDR_W | Remote descriptor base for init |
| overflow | output | 1 | Sticky overflow flag |
| busy | output | 1 | Remote sequence in progress |
| bus_req | output | 1 | Remote bus request |
| bus_ack | input | 1 | Remote bus grant |
| mem_addr | output | ADDR_W | Remote access address |
| mem_we | output | 1 | Remote write strobe |
| mem_re | output | 1 | Remote read strobe |
| mem_wdata | output | DATA_W | Remote write data |
| mem_rdata | input | DATA_W | Remote read data |

## Verification
The bench drives the read count through the wrap from 255 to 0. A design that compares unmasked counts there would either refuse every later pop or hand out stale bytes.

It fills the store to 255 unread bytes and then adds one more. This exposes an off-by-one in the overflow threshold, or a design that drops the byte instead of overwriting.

During a long bus grant it issues a second pop and a fresh strobe. A design that accepted the pop would skip a byte, and one that gated capture on bus ownership would lose the strobed byte.

The write-back target is checked in remote memory at base-1 after each sequence, so a wrong offset or a stale count shows up there.

// File: rtl/msgcap_pkg.sv
package msgcap_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WB_ACQ,
        ST_WB_WRITE,
        ST_IN_ACQ,
        ST_IN_READ,
        ST_IN_LATCH,
        ST_IN_WRITE,
        ST_RELEASE
    } seq_state_e;

    localparam int WB_OFFSET  = 1;  // output index sits one below base
    localparam int IN_OFFSET  = 2;  // input index sits two below base

endpackage

// File: rtl/msgcap_strobe_sync.sv
module msgcap_strobe_sync #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              cap_pulse,
    output logic [DATA_W-1:0] cap_data
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0]             sync_q;
    logic [SYNC_STAGES-1:0][DATA_W-1:0] data_q;
    logic                               prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_n};
            prev_q <= sync_q[LAST];
        end
    end

    // data travels alongside the strobe so the captured value lines up
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q[0] <= data_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                data_q[i] <= data_q[i-1];
            end
        end
    end

    assign cap_pulse = prev_q & ~sync_q[LAST];
    assign cap_data  = data_q[LAST];

endmodule

// File: rtl/msgcap_ring.sv
module msgcap_ring #(
    parameter int DATA_W     = 8,
    parameter int DEPTH_LOG2 = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_pulse,
    input  logic [DATA_W-1:0]     cap_data,
    input  logic                  pop_take,
    output logic                  empty,
    output logic [DATA_W-1:0]     head_data,
    output logic [DEPTH_LOG2-1:0] rd_idx,
    output logic                  overflow
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2-1:0] FILL_LIMIT = DEPTH_LOG2'(DEPTH - 1);

    logic [DATA_W-1:0]     store [DEPTH];
    logic [DEPTH_LOG2-1:0] wr_q;
    logic [DEPTH_LOG2-1:0] rd_q;
    logic [DEPTH_LOG2-1:0] fill;
    logic                  ovf_q;

    assign fill = wr_q - rd_q;

    always_ff @(posedge clk) begin
        if (cap_pulse) begin
            store[wr_q] <= cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            ovf_q <= 1'b0;
        end else if (cap_pulse) begin
            wr_q <= wr_q + 1'b1;
            if (fill == FILL_LIMIT) begin
                ovf_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (pop_take) begin
            rd_q <= rd_q + 1'b1;
        end
    end

    assign empty     = (wr_q == rd_q);
    assign head_data = store[rd_q];
    assign rd_idx    = rd_q;
    assign overflow  = ovf_q;

endmodule

// File: rtl/msgcap_seq.sv
module msgcap_seq
    import msgcap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wb,
    input  logic              start_init,
    input  logic [ADDR_W-1:0] init_base,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] base_q
);
    localparam logic [ADDR_W-1:0] OFS_OUT = ADDR_W'(WB_OFFSET);
    localparam logic [ADDR_W-1:0] OFS_IN  = ADDR_W'(IN_OFFSET);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pend_base_q;
    logic [DATA_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_init)    state_d = ST_IN_ACQ;
                else if (start_wb) state_d = ST_WB_ACQ;
            end
            ST_WB_ACQ:   if (bus_ack) state_d = ST_WB_WRITE;
            ST_WB_WRITE: if (bus_ack) state_d = ST_RELEASE;
            ST_IN_ACQ:   if (bus_ack) state_d = ST_IN_READ;
            ST_IN_READ:  if (bus_ack) state_d = ST_IN_LATCH;
            ST_IN_LATCH: state_d = ST_IN_WRITE;
            ST_IN_WRITE: if (bus_ack) state_d = ST_RELEASE;
            ST_RELEASE:  if (!bus_ack) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_base_q <= '0;
            idx_q       <= '0;
            base_q      <= '0;
        end else begin
            if (state_q == ST_IDLE && start_init) begin
                pend_base_q <= init_base;
            end
            if (state_q == ST_IN_LATCH) begin
                idx_q <= mem_rdata;
            end
            if (state_q == ST_IN_WRITE && bus_ack) begin
                base_q <= pend_base_q;
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE, ST_RELEASE: begin
                bus_req = 1'b0;
            end
            ST_WB_ACQ, ST_IN_ACQ, ST_IN_LATCH: begin
                bus_req = 1'b1;
            end
            ST_WB_WRITE: begin
                bus_req   = 1'b1;
                mem_we    = bus_ack;
                mem_addr  = base_q - OFS_OUT;
                mem_wdata = wb_value;
            end
            ST_IN_READ: begin
                bus_req  = 1'b1;
                mem_re   = bus_ack;
                mem_addr = pend_base_q - OFS_IN;
            end
            ST_IN_WRITE: begin
                bus_req   = 1'b1;
                mem_we    = bus_ack;
                mem_addr  = pend_base_q - OFS_OUT;
                mem_wdata = idx_q;
            end
            default: bus_req = 1'b0;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/msgcap_snoop_buffer.sv
module msgcap_snoop_buffer #(
    parameter int DATA_W      = 8,
    parameter int DEPTH_LOG2  = 8,
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [DATA_W-1:0] snoop_data,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic              init_req,
    input  logic [ADDR_W-1:0] init_base,
    output logic              overflow,
    output logic              busy,
    output logic              bus_req,
    input  logic              bus_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic                  cap_pulse;
    logic [DATA_W-1:0]     cap_data;
    logic                  empty;
    logic [DATA_W-1:0]     head_data;
    logic [DEPTH_LOG2-1:0] rd_idx;
    logic [DEPTH_LOG2-1:0] rd_next;
    logic                  pop_take;
    logic                  start_init;
    logic                  start_wb;
    logic [ADDR_W-1:0]     base_q;
    logic                  seq_busy;

    msgcap_strobe_sync #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_n  (strobe_n),
        .data_in   (snoop_data),
        .cap_pulse (cap_pulse),
        .cap_data  (cap_data)
    );

    msgcap_ring #(
        .DATA_W     (DATA_W),
        .DEPTH_LOG2 (DEPTH_LOG2)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pulse (cap_pulse),
        .cap_data  (cap_data),
        .pop_take  (pop_take),
        .empty     (empty),
        .head_data (head_data),
        .rd_idx    (rd_idx),
        .overflow  (overflow)
    );

    assign start_init = init_req & ~seq_busy;
    assign pop_take   = pop_req & ~seq_busy & ~init_req & ~empty;
    assign start_wb   = pop_take & (base_q != '0);
    assign rd_next    = rd_idx;

    msgcap_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wb   (start_wb),
        .start_init (start_init),
        .init_base  (init_base),
        .wb_value   (DATA_W'(rd_next)),
        .bus_ack    (bus_ack),
        .mem_rdata  (mem_rdata),
        .bus_req    (bus_req),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_wdata  (mem_wdata),
        .busy       (seq_busy),
        .base_q     (base_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_valid <= 1'b0;
            pop_data  <= '0;
        end else begin
            pop_valid <= pop_take;
            if (pop_take) begin
                pop_data <= head_data;
            end
        end
    end

    assign busy = seq_busy;

endmodule

// File: rtl/msgcap_checker.sv
module msgcap_checker (
    input logic clk,
    input logic rst_n,
    input logic pop_req,
    input logic pop_valid,
    input logic busy,
    input logic overflow,
    input logic bus_req,
    input logic bus_ack,
    input logic mem_we,
    input logic mem_re
);
    p_access_owned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (bus_req && bus_ack));

    p_single_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    p_pop_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> ($past(pop_req) && !$past(busy)));

    p_overflow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_idle_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    p_write_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind msgcap_snoop_buffer msgcap_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_req   (pop_req),
    .pop_valid (pop_valid),
    .busy      (busy),
    .overflow  (overflow),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
);

// File: tb/sim_msgcap_snoop_buffer.sv
`timescale 1ns/1ps
module sim_msgcap_snoop_buffer;
    localparam int ADDR_W = 16;
    localparam int NVEC   = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'h3C, 8'hA5, 8'h00, 8'hFF,
                                          8'h81, 8'h7E, 8'h12, 8'hED};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              strobe_n = 1'b1;
    logic [7:0]        snoop_data = '0;
    logic              pop_req = 1'b0;
    logic              pop_valid;
    logic [7:0]        pop_data;
    logic              init_req = 1'b0;
    logic [ADDR_W-1:0] init_base = '0;
    logic              overflow, busy, bus_req, mem_we, mem_re;
    logic              bus_ack = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = '0;

    msgcap_snoop_buffer u0 (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .snoop_data(snoop_data),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .init_req(init_req), .init_base(init_base), .overflow(overflow),
        .busy(busy), .bus_req(bus_req), .bus_ack(bus_ack), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] rmem [256];
    int ack_lat = 1;
    int ack_cnt = 0;
    int req_rises = 0;
    int acc_bad = 0;
    logic req_prev = 1'b0;
    int n_checks = 0;
    int n_fail = 0;
    int rcount = 0;

    // remote bus responder, acting on the falling clock edge
    always @(negedge clk) begin
        if ((mem_we || mem_re) && !(bus_req && bus_ack)) acc_bad++;
        if (mem_we) rmem[mem_addr[7:0]] = mem_wdata;
        if (mem_re) mem_rdata <= rmem[mem_addr[7:0]];
        if (bus_req && !req_prev) req_rises++;
        req_prev = bus_req;
        if (bus_req) begin
            ack_cnt++;
            bus_ack <= (ack_cnt >= ack_lat);
        end else begin
            ack_cnt = 0;
            bus_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] v);
        @(negedge clk);
        snoop_data = v;
        strobe_n = 1'b0;
        repeat (3) @(negedge clk);
        strobe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pop(output logic v, output logic [7:0] d);
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        v = pop_valid;
        d = pop_data;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic       v;
        logic [7:0] d;
        for (int i = 0; i < 256; i++) rmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!pop_valid && !overflow && !busy && !bus_req && !mem_we && !mem_re,
            "R1", {pop_valid, overflow, busy, bus_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: empty pop refused
        pop(v, d);
        chk(v == 1'b0, "R3", v, 0);

        // R2/R4: table walk, FIFO order
        for (int i = 0; i < NVEC; i++) strobe(VEC[i]);
        for (int i = 0; i < NVEC; i++) begin
            pop(v, d);
            chk(v && d == VEC[i], "R4", d, VEC[i]);
            rcount++;
        end
        pop(v, d);
        chk(v == 1'b0, "R3", v, 0);
        // R7: base still zero, no bus traffic
        chk(req_rises == 0, "R7", req_rises, 0);

        // R8: init copies input index to output index
        rmem[8'h3E] = 8'h5A;
        rmem[8'h3F] = 8'h00;
        @(negedge clk);
        init_base = 16'h0040;
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        wait_idle();
        chk(rmem[8'h3F] == 8'h5A, "R8", rmem[8'h3F], 8'h5A);
        chk(!bus_req, "R6", bus_req, 0);

        // R6/R9/R10: slow grant, pop and strobe during sequence
        ack_lat = 20;
        strobe(8'h55);
        strobe(8'h66);
        pop(v, d);
        chk(v && d == 8'h55, "R4", d, 8'h55);
        rcount++;
        pop(v, d);
        chk(v == 1'b0, "R9", v, 0);
        strobe(8'h77);
        chk(busy == 1'b1, "R10", busy, 1);
        wait_idle();
        chk(rmem[8'h3F] == 8'(rcount), "R6", rmem[8'h3F], rcount);
        ack_lat = 1;
        pop(v, d);
        chk(v && d == 8'h66, "R9", d, 8'h66);
        rcount++;
        wait_idle();
        pop(v, d);
        chk(v && d == 8'h77, "R10", d, 8'h77);
        rcount++;
        wait_idle();

        // R4: read count wraps through 255
        for (int i = 0; i < 255; i++) strobe(8'(i));
        chk(overflow == 1'b0, "R5", overflow, 0);
        for (int i = 0; i < 255; i++) begin
            pop(v, d);
            chk(v && d == 8'(i), "R4", d, i);
            rcount++;
            wait_idle();
        end
        chk(rmem[8'h3F] == 8'(rcount), "R4", rmem[8'h3F], rcount & 255);

        // R5: 256th unread byte trips overflow
        for (int i = 0; i < 255; i++) strobe(8'hC3);
        chk(overflow == 1'b0, "R5", overflow, 0);
        strobe(8'h99);
        chk(overflow == 1'b1, "R5", overflow, 1);
        pop(v, d);
        chk(v == 1'b0, "R5", v, 0);

        // R11: every access seen while owned
        chk(acc_bad == 0, "R11", acc_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule